// File: doc/BRIEF.md
# Receive Link Fault Monitor

This block watches one channel of a deserializing receiver and raises a link fault flag when the incoming signal cannot be trusted. It receives recovered characters with a valid strobe in the receive clock domain, plus a set of single-bit status results from analog and clocking logic elsewhere in the receiver. These are an amplitude-above-threshold flag with its 2-bit threshold code, a recovered-frequency-in-range flag, a channel enable, a reference-clock-present flag and a forced-fault control.

The flag is low only when six things hold together. The amplitude test must pass or be switched off, the bit stream must show transitions often enough, the frequency must be in range, the channel must be enabled, the reference clock must be present, and no fault may be forced. Transition density is judged bit by bit across character boundaries. The block also watches a line-select input that names the active line receiver. Any change of that selection starts the transition count again, so a run from one receiver never counts against the other.

Top module: `linkFaultMon`

## Requirements
- R1: While reset is asserted, and in the cycles that follow it until an evaluation finds every condition valid, `linkFault` is 1.
- R2: `linkFault` is 1 whenever any of these holds: `rangeOk` is low, `chanEn` is low, `refClkOk` is low, `forceFault` is high, the amplitude condition fails, or the density condition fails. Otherwise it is 0.
- R3: When `ampSel` is 2'b00 the amplitude condition passes whatever `ampOk` is. For 2'b01, 2'b10 and 2'b11 it passes only while `ampOk` is 1.
- R4: The density condition fails when 60 or more consecutive received bits are equal. A longest run of 59 equal bits keeps it passing.
- R5: `charData[0]` is the first bit received and `charData[9]` the last. The run count continues across characters, comparing bit 9 of one character with bit 0 of the next. A 60-bit run that begins and ends inside characters is therefore detected.
- R6: A change of `lineSel` clears the run count and the density failure at the next clock edge, with no predecessor bit kept.
- R7: While the synchronized channel enable is low, the run is held at its fault value. After re-enable the density failure stays until a character is received.
- R8: `linkFault` is a register in the receive clock domain. A change on a status input reaches it on the third rising edge, after two synchronizer flops. A received character affects it on the second edge.
- R9: Without `charValid` the run state does not change, so a density fault persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charData | input | 10 | Recovered character, bit 0 received first |
| charValid | input | 1 | Character strobe |
| lineSel | input | 1 | Active line receiver select |
| ampSel | input | 2 | Amplitude threshold code, 00 = amplitude test off |
| ampOk | input | 1 | Amplitude above selected threshold (asynchronous) |
| rangeOk | input | 1 | Recovered frequency within range (asynchronous) |
| chanEn | input | 1 | Receive channel enable (asynchronous) |
| refClkOk | input | 1 | Reference clock present (asynchronous) |
| forceFault | input | 1 | Force the fault indication (asynchronous) |
| linkFault | output | 1 | Link fault indicator, active high |

## Verification
The assertions check several things on every cycle. The run count never goes past its limit. A forced fault or a density failure is always followed by a raised flag. A cleared flag always follows synchronized status that was valid. A disable holds the run state saturated, a selection change clears it, and idle cycles leave it alone. Only the bench scenarios can show the exact 59 and 60 bit boundary, runs that cross character edges, the threshold-code bypass and the three-edge latency. They do this against a bit-serial model that is compared on every clock.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  // strobes from control to datapath, hold has top priority
  typedef struct packed {
    logic hold;
    logic restart;
    logic load;
  } runStrobe_t;
endpackage

// File: rtl/lfmSync.sv
module lfmSync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/lfmCtrl.sv
module lfmCtrl
  import lfm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic       lineSel,
  input  logic       enS,
  output runStrobe_t strobe,
  output logic       selSwitch
);
  logic prevSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSel <= 1'b0;
    else       prevSel <= lineSel;
  end

  assign selSwitch = (lineSel != prevSel);

  always_comb begin
    strobe.hold    = !enS;
    strobe.restart = enS && selSwitch;
    strobe.load    = enS && !selSwitch && charValid;
  end
endmodule

// File: rtl/lfmDatapath.sv
module lfmDatapath
  import lfm_pkg::*;
#(
  parameter int CHAR_W    = 10,
  parameter int RUN_LIMIT = 60,
  localparam int RUN_W    = $clog2(RUN_LIMIT + 1),
  localparam int CNT_W    = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  runStrobe_t        strobe,
  input  logic [CHAR_W-1:0] charData,
  input  logic [1:0]        ampSel,
  input  logic              ampS,
  input  logic              rangeS,
  input  logic              enS,
  input  logic              refS,
  input  logic              forceS,
  output logic [RUN_W-1:0]  runCnt,
  output logic              densBad,
  output logic              linkFault
);
  localparam logic [RUN_W:0]   LIM_X = (RUN_W+1)'(RUN_LIMIT);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(CHAR_W);

  logic              lastBit;
  logic              lastValid;
  logic [CNT_W-1:0]  leadLen;
  logic [CNT_W-1:0]  tailLen;
  logic              stopL;
  logic              stopT;
  logic [RUN_W:0]    peak;
  logic [RUN_W-1:0]  peakSat;
  logic [RUN_W-1:0]  nextRun;
  logic              joins;
  logic              allOk;

  // leading run from bit 0 and trailing run from the last bit
  always_comb begin
    leadLen = '0;
    stopL   = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (!stopL && (charData[i] == charData[0])) leadLen = leadLen + 1'b1;
      else stopL = 1'b1;
    end
    tailLen = '0;
    stopT   = 1'b0;
    for (int j = CHAR_W - 1; j >= 0; j--) begin
      if (!stopT && (charData[j] == charData[CHAR_W-1])) tailLen = tailLen + 1'b1;
      else stopT = 1'b1;
    end
  end

  always_comb begin
    joins   = lastValid && (charData[0] == lastBit);
    peak    = joins ? ({1'b0, runCnt} + (RUN_W+1)'(leadLen)) : (RUN_W+1)'(leadLen);
    peakSat = (peak >= LIM_X) ? RUN_W'(RUN_LIMIT) : peak[RUN_W-1:0];
    nextRun = (leadLen == FULL) ? peakSat : RUN_W'(tailLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= RUN_W'(RUN_LIMIT);
      densBad   <= 1'b1;
      lastBit   <= 1'b0;
      lastValid <= 1'b0;
    end else if (strobe.hold) begin
      runCnt    <= RUN_W'(RUN_LIMIT);
      densBad   <= 1'b1;
      lastValid <= 1'b0;
    end else if (strobe.restart) begin
      runCnt    <= '0;
      densBad   <= 1'b0;
      lastValid <= 1'b0;
    end else if (strobe.load) begin
      runCnt    <= nextRun;
      densBad   <= (peak >= LIM_X);
      lastBit   <= charData[CHAR_W-1];
      lastValid <= 1'b1;
    end
  end

  always_comb begin
    allOk = ((ampSel == 2'b00) || ampS) && rangeS && enS && refS && !forceS && !densBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linkFault <= 1'b1;
    else       linkFault <= !allOk;
  end
endmodule

// File: rtl/linkFaultMon.sv
module linkFaultMon
  import lfm_pkg::*;
#(
  parameter int CHAR_W    = 10,
  parameter int RUN_LIMIT = 60,
  localparam int RUN_W    = $clog2(RUN_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] charData,
  input  logic              charValid,
  input  logic              lineSel,
  input  logic [1:0]        ampSel,
  input  logic              ampOk,
  input  logic              rangeOk,
  input  logic              chanEn,
  input  logic              refClkOk,
  input  logic              forceFault,
  output logic              linkFault
);
  logic [4:0]       statusS;
  runStrobe_t       strobe;
  logic             selSwitch;
  logic [RUN_W-1:0] runCnt;
  logic             densBad;
  logic             ampS, rangeS, chanEnS, refS, forceS;

  lfmSync #(.WIDTH(5)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({forceFault, refClkOk, chanEn, rangeOk, ampOk}),
    .syncOut(statusS)
  );

  assign ampS    = statusS[0];
  assign rangeS  = statusS[1];
  assign chanEnS = statusS[2];
  assign refS    = statusS[3];
  assign forceS  = statusS[4];

  lfmCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .lineSel(lineSel),
    .enS(chanEnS), .strobe(strobe), .selSwitch(selSwitch)
  );

  lfmDatapath #(.CHAR_W(CHAR_W), .RUN_LIMIT(RUN_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .charData(charData),
    .ampSel(ampSel), .ampS(ampS), .rangeS(rangeS), .enS(chanEnS),
    .refS(refS), .forceS(forceS), .runCnt(runCnt), .densBad(densBad),
    .linkFault(linkFault)
  );
endmodule

// File: rtl/lfmChecker.sv
module lfmChecker #(
  parameter int RUN_LIMIT = 60,
  localparam int RUN_W    = $clog2(RUN_LIMIT + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             charValid,
  input logic             selSwitch,
  input logic             enS,
  input logic             rangeS,
  input logic             refS,
  input logic             forceS,
  input logic [RUN_W-1:0] runCnt,
  input logic             densBad,
  input logic             linkFault
);
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_W'(RUN_LIMIT));

  p_dens_fault_r4: assert property (@(posedge clk) disable iff (!rstN)
    densBad |=> linkFault);

  p_force_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
    forceS |=> linkFault);

  p_clear_needs_ok_r2: assert property (@(posedge clk) disable iff (!rstN)
    !linkFault |-> $past(rangeS && refS && enS && !forceS));

  p_disable_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enS |=> (densBad && runCnt == RUN_W'(RUN_LIMIT)));

  p_sel_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enS && selSwitch) |=> (runCnt == '0 && !densBad));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enS && !selSwitch && !charValid) |=> ($stable(runCnt) && $stable(densBad)));
endmodule

bind linkFaultMon lfmChecker #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
  .clk(clk), .rstN(rstN), .charValid(charValid), .selSwitch(selSwitch),
  .enS(chanEnS), .rangeS(rangeS), .refS(refS), .forceS(forceS),
  .runCnt(runCnt), .densBad(densBad), .linkFault(linkFault)
);

// File: tb/linkFaultMon_bench.sv
module linkFaultMon_bench;
  localparam int PERIOD = 10;
  localparam int LIM    = 60;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] charData = '0;
  logic       charValid = 1'b0;
  logic       lineSel = 1'b0;
  logic [1:0] ampSel = 2'b00;
  logic       ampOk = 1'b0, rangeOk = 1'b0, chanEn = 1'b0, refClkOk = 1'b0, forceFault = 1'b0;
  logic       linkFault;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  linkFaultMon u_linkFaultMon (
    .clk(clk), .rstN(rstN), .charData(charData), .charValid(charValid),
    .lineSel(lineSel), .ampSel(ampSel), .ampOk(ampOk), .rangeOk(rangeOk),
    .chanEn(chanEn), .refClkOk(refClkOk), .forceFault(forceFault),
    .linkFault(linkFault)
  );

  // behavioural reference: bit-serial run counting, status delay lines
  logic [4:0] mS1, mS2;
  logic       mPrev, mLast, mHave, mBad, mFault, hit;
  int         mRun;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = 1'b0; mLast = 1'b0; mHave = 1'b0;
      mBad = 1'b1; mRun = LIM; mFault = 1'b1;
    end else begin
      mFault = !(((ampSel == 2'b00) || mS2[0]) && mS2[1] && mS2[2] && mS2[3]
                 && !mS2[4] && !mBad);
      if (!mS2[2]) begin
        mRun = LIM; mHave = 1'b0; mBad = 1'b1;
      end else if (lineSel != mPrev) begin
        mRun = 0; mHave = 1'b0; mBad = 1'b0;
      end else if (charValid) begin
        hit = 1'b0;
        for (int i = 0; i < 10; i++) begin
          if (mHave && charData[i] == mLast) mRun = (mRun + 1 > LIM) ? LIM : mRun + 1;
          else mRun = 1;
          if (mRun >= LIM) hit = 1'b1;
          mLast = charData[i];
          mHave = 1'b1;
        end
        mBad = hit;
      end
      mPrev = lineSel;
      mS2 = mS1;
      mS1 = {forceFault, refClkOk, chanEn, rangeOk, ampOk};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (linkFault !== mFault) begin
        fails++;
        $display("FAIL R2/R8 per-cycle model at %0t: actual=%b expected=%b", $time, linkFault, mFault);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag);
    vectors++;
    if (linkFault !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, linkFault, exp);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finishRun();
  end

  initial begin
    tick(3);
    chk(1'b1, "R1 during reset");
    rstN = 1'b1;
    tick(1);
    chk(1'b1, "R1 after reset");

    ampSel = 2'b10; ampOk = 1'b1; rangeOk = 1'b1; chanEn = 1'b1; refClkOk = 1'b1;
    charValid = 1'b1; charData = 10'h155;
    tick(6);
    chk(1'b0, "R2 all valid");

    forceFault = 1'b1;
    tick(2); chk(1'b0, "R8 two edges");
    tick(1); chk(1'b1, "R8 third edge");
    forceFault = 1'b0;
    tick(4); chk(1'b0, "R2 force released");

    rangeOk = 1'b0; tick(4); chk(1'b1, "R2 range");
    rangeOk = 1'b1; tick(4); chk(1'b0, "R2 range back");
    refClkOk = 1'b0; tick(4); chk(1'b1, "R2 refclk");
    refClkOk = 1'b1; tick(4); chk(1'b0, "R2 refclk back");

    ampOk = 1'b0; ampSel = 2'b00; tick(4); chk(1'b0, "R3 code 00 bypass");
    ampSel = 2'b01; tick(2); chk(1'b1, "R3 code 01 needs amp");
    ampSel = 2'b11; tick(2); chk(1'b1, "R3 code 11 needs amp");
    ampOk = 1'b1; tick(4); chk(1'b0, "R3 amp back");

    // 59-bit zero run: 0x2AA ends in 1, five zero chars, then nine zeros
    charData = 10'h2AA; tick(1);
    charData = 10'h000; tick(5);
    charData = 10'h200; tick(1);
    charData = 10'h2AA; tick(2);
    chk(1'b0, "R4 run of 59");

    charData = 10'h000; tick(6);
    charValid = 1'b0; tick(1);
    chk(1'b1, "R4 run of 60");
    tick(5);
    chk(1'b1, "R9 no chars keeps fault");

    lineSel = 1'b1; tick(2);
    chk(1'b0, "R6 select switch restarts");

    // run spanning characters: 5 + 50 + 5 zeros
    charValid = 1'b1;
    charData = 10'h01F; tick(1);
    charData = 10'h000; tick(5);
    charData = 10'h3E0; tick(1);
    charData = 10'h155; tick(1);
    chk(1'b1, "R5 cross-character run");
    tick(1);
    chk(1'b0, "R5 transitions resume");

    for (int k = 0; k < 8; k++) begin
      charData = k[0] ? 10'h000 : 10'h3FF;
      tick(1);
    end
    tick(1);
    chk(1'b0, "R5 boundary transitions");
    charData = 10'h155;

    chanEn = 1'b0; tick(3);
    chk(1'b1, "R7 disabled");
    charValid = 1'b0; chanEn = 1'b1; tick(6);
    chk(1'b1, "R7 held after re-enable");
    charValid = 1'b1; tick(2);
    chk(1'b0, "R7 released by character");

    tick(2);
    finishRun();
  end
endmodule